// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block sits on the host side of a PCIe-style root port and rewrites outgoing memory addresses. It keeps a small bank of programmable windows. Each window holds a base, an inclusive limit, a target and a transaction type. When a request address falls inside an enabled outbound window, the unit replaces the address with `target + (address - base)` and reports the window's type together with a hit flag. An address that no window covers leaves unchanged, with the hit flag low and the type set to memory.

Software programs the windows through a simple 32-bit register port. It writes with a one-cycle strobe and reads combinationally from the addressed location. The usual sequence disables a window, rewrites its fields, enables it again, and reads the enable bit back.

Configuration-type windows place the bus, device and function numbers in the upper half of the low target word, so the request's low offset bits become the register offset within that function. An extended-limit mode lets a window reach past a 4 GiB boundary.

Top module: `outbound_xlate`

## Requirements
- R1: After reset every window is disabled, every register reads zero, and `outValid` is low.
- R2: Window `i` (0 to 7) occupies byte addresses `0x300000 + i*0x100`. Its field offsets are: 0x00 control-1, 0x04 control-2, 0x08 base low, 0x0C base high, 0x10 limit low, 0x14 target low, 0x18 target high, 0x20 limit high. `regRdData` reflects the addressed field in the same cycle. Control-1 keeps bits [13] and [10:0] only, so a write of all ones reads back 0x000027FF. Control-2 keeps bit 31 (enable) only, so a write of all ones reads back 0x80000000. The other fields keep all 32 bits.
- R3: Unused offsets inside a window, and addresses outside the window range, read as zero. Writes to them change no stored field.
- R4: An enabled even-index window hits when `base <= reqAddr <= limit`, with the limit inclusive. A hit returns `outAddr = target + (reqAddr - base)`, `outType` = control-1 bits [4:0] (memory=0, I/O=2, config type 0=4, config type 1=5), and `outHit` = 1.
- R5: A request that hits no window returns `outAddr = reqAddr`, `outHit` = 0 and `outType` = 0.
- R6: A window whose control-2 bit 31 is 0 never hits.
- R7: Odd-index windows (index bit 0 = 1, the inbound set) are stored and read back, but never take part in translation.
- R8: With control-1 bit 13 = 0, the upper 32 bits of the limit equal the upper base word. With bit 13 = 1, they come from the limit-high register.
- R9: When several enabled outbound windows cover the same address, the lowest index wins.
- R10: A config window whose target low word holds bus [31:24], device [23:19] and function [18:16] yields those fields unchanged in `outAddr[31:16]`, with the request offset from base in the bits below.
- R11: A request presented at one clock edge produces its result, with `outValid` high, after that edge. `outValid` is low after an edge with no request. A register write takes effect for a request presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 22 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| reqValid | input | 1 | Translation request valid |
| reqAddr | input | 64 | Host-side request address |
| outValid | output | 1 | Result valid, one cycle after request |
| outHit | output | 1 | Request matched an outbound window |
| outAddr | output | 64 | Translated or passed-through address |
| outType | output | 5 | Transaction type of the matching window |

## Verification
Register reads are combinational, so the bench samples `regRdData` a short delay after it changes `regAddr`, with no clock edge in between. Translation results are due one edge after a request. The bench drives each request on a falling edge and samples the outputs on the next falling edge, which sits after the single capturing rising edge. Write-to-use ordering is exercised by driving a request on the falling edge right after a write strobe, so the request meets its capturing edge one cycle after the write.

// File: rtl/outbound_xlate_pkg.sv
package outbound_xlate_pkg;

  localparam int REGION_IDX_W     = 3;
  localparam int NUM_REGIONS      = 1 << REGION_IDX_W;
  localparam int REGION_STRIDE_LG2 = 8;
  localparam int DATA_W           = 32;
  localparam int ADDR_W           = 2 * DATA_W;
  localparam int TYPE_W           = 5;

  // Byte offsets of each field inside one window
  localparam logic [REGION_STRIDE_LG2-1:0] OFS_CTRL1   = 8'h00;
  localparam logic [REGION_STRIDE_LG2-1:0] OFS_CTRL2   = 8'h04;
  localparam logic [REGION_STRIDE_LG2-1:0] OFS_BASE_LO = 8'h08;
  localparam logic [REGION_STRIDE_LG2-1:0] OFS_BASE_HI = 8'h0C;
  localparam logic [REGION_STRIDE_LG2-1:0] OFS_LIM_LO  = 8'h10;
  localparam logic [REGION_STRIDE_LG2-1:0] OFS_TGT_LO  = 8'h14;
  localparam logic [REGION_STRIDE_LG2-1:0] OFS_TGT_HI  = 8'h18;
  localparam logic [REGION_STRIDE_LG2-1:0] OFS_LIM_HI  = 8'h20;

  // Bit positions inside control words
  localparam int CTRL1_EXT_BIT = 13;
  localparam int CTRL2_EN_BIT  = 31;

  typedef enum logic [3:0] {
    FLD_NONE, FLD_CTRL1, FLD_CTRL2, FLD_BASE_LO, FLD_BASE_HI,
    FLD_LIM_LO, FLD_TGT_LO, FLD_TGT_HI, FLD_LIM_HI
  } fieldSel_e;

  typedef struct packed {
    logic                    wrEn;
    logic [REGION_IDX_W-1:0] idx;
    fieldSel_e               field;
  } regStrobe_t;

  // Windows whose index has bit 0 clear are outbound
  function automatic logic [NUM_REGIONS-1:0] outboundMask();
    logic [NUM_REGIONS-1:0] m;
    for (int i = 0; i < NUM_REGIONS; i++) m[i] = ((i % 2) == 0);
    return m;
  endfunction

endpackage

// File: rtl/outbound_xlate_ctrl.sv
module outbound_xlate_ctrl
  import outbound_xlate_pkg::*;
#(
  parameter int REG_AW = 22,
  parameter logic [REG_AW-1:0] REGION_BASE = 22'h300000
) (
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  output regStrobe_t        stb
);

  localparam int LOW_W = REGION_STRIDE_LG2 + REGION_IDX_W;
  localparam logic [REG_AW-1:0] WIN_SIZE = REG_AW'(NUM_REGIONS << REGION_STRIDE_LG2);
  localparam logic [REG_AW-1:0] WIN_END  = REGION_BASE + WIN_SIZE;

  logic                          inWindow;
  logic [REG_AW-1:0]             relAddr;
  logic [LOW_W-1:0]              relLow;
  logic [REGION_STRIDE_LG2-1:0]  fieldOfs;
  fieldSel_e                     fieldDec;

  assign inWindow = (regAddr >= REGION_BASE) && (regAddr < WIN_END);
  assign relAddr  = regAddr - REGION_BASE;
  assign relLow   = relAddr[LOW_W-1:0];
  assign fieldOfs = relLow[REGION_STRIDE_LG2-1:0];

  always_comb begin
    fieldDec = FLD_NONE;
    if (inWindow) begin
      case (fieldOfs)
        OFS_CTRL1:   fieldDec = FLD_CTRL1;
        OFS_CTRL2:   fieldDec = FLD_CTRL2;
        OFS_BASE_LO: fieldDec = FLD_BASE_LO;
        OFS_BASE_HI: fieldDec = FLD_BASE_HI;
        OFS_LIM_LO:  fieldDec = FLD_LIM_LO;
        OFS_TGT_LO:  fieldDec = FLD_TGT_LO;
        OFS_TGT_HI:  fieldDec = FLD_TGT_HI;
        OFS_LIM_HI:  fieldDec = FLD_LIM_HI;
        default:     fieldDec = FLD_NONE;
      endcase
    end
  end

  always_comb begin
    stb.field = fieldDec;
    stb.idx   = relLow[LOW_W-1:REGION_STRIDE_LG2];
    stb.wrEn  = regWrEn && (fieldDec != FLD_NONE);
  end

  // Unused relAddr upper bits only matter through inWindow
  logic unusedRel;
  assign unusedRel = ^relAddr[REG_AW-1:LOW_W];

endmodule

// File: rtl/outbound_xlate_regs.sv
module outbound_xlate_regs
  import outbound_xlate_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  regStrobe_t                          stb,
  input  logic [DATA_W-1:0]                   wrData,
  output logic [DATA_W-1:0]                   rdData,
  output logic [NUM_REGIONS-1:0]              regEn,
  output logic [NUM_REGIONS-1:0]              regExt,
  output logic [NUM_REGIONS-1:0][TYPE_W-1:0]  regType,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0]  regBase,
  output logic [NUM_REGIONS-1:0][DATA_W-1:0]  regLimLo,
  output logic [NUM_REGIONS-1:0][DATA_W-1:0]  regLimHi,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0]  regTarget
);

  logic [NUM_REGIONS-1:0][2:0] tcQ;
  logic [NUM_REGIONS-1:0]      tdQ;
  logic [NUM_REGIONS-1:0][1:0] attrQ;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    logic selHere;
    assign selHere = stb.wrEn && (stb.idx == REGION_IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        regEn[g]     <= 1'b0;
        regExt[g]    <= 1'b0;
        regType[g]   <= '0;
        tcQ[g]       <= '0;
        tdQ[g]       <= 1'b0;
        attrQ[g]     <= '0;
        regBase[g]   <= '0;
        regLimLo[g]  <= '0;
        regLimHi[g]  <= '0;
        regTarget[g] <= '0;
      end else if (selHere) begin
        case (stb.field)
          FLD_CTRL1: begin
            regType[g] <= wrData[TYPE_W-1:0];
            tcQ[g]     <= wrData[7:5];
            tdQ[g]     <= wrData[8];
            attrQ[g]   <= wrData[10:9];
            regExt[g]  <= wrData[CTRL1_EXT_BIT];
          end
          FLD_CTRL2:   regEn[g] <= wrData[CTRL2_EN_BIT];
          FLD_BASE_LO: regBase[g][DATA_W-1:0]        <= wrData;
          FLD_BASE_HI: regBase[g][ADDR_W-1:DATA_W]   <= wrData;
          FLD_LIM_LO:  regLimLo[g]                   <= wrData;
          FLD_LIM_HI:  regLimHi[g]                   <= wrData;
          FLD_TGT_LO:  regTarget[g][DATA_W-1:0]      <= wrData;
          FLD_TGT_HI:  regTarget[g][ADDR_W-1:DATA_W] <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (stb.field)
      FLD_CTRL1:   rdData = {18'b0, regExt[stb.idx], 2'b0, attrQ[stb.idx],
                             tdQ[stb.idx], tcQ[stb.idx], regType[stb.idx]};
      FLD_CTRL2:   rdData = {regEn[stb.idx], 31'b0};
      FLD_BASE_LO: rdData = regBase[stb.idx][DATA_W-1:0];
      FLD_BASE_HI: rdData = regBase[stb.idx][ADDR_W-1:DATA_W];
      FLD_LIM_LO:  rdData = regLimLo[stb.idx];
      FLD_LIM_HI:  rdData = regLimHi[stb.idx];
      FLD_TGT_LO:  rdData = regTarget[stb.idx][DATA_W-1:0];
      FLD_TGT_HI:  rdData = regTarget[stb.idx][ADDR_W-1:DATA_W];
      default:     rdData = '0;
    endcase
  end

  // R3: the decoder never strobes a write without a field
  p_no_stray_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> (stb.field != FLD_NONE));

  // R2: a control-2 write lands in the enable bit of the addressed window
  p_enable_takes_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && stb.field == FLD_CTRL2) |=>
      (regEn[$past(stb.idx)] == $past(wrData[CTRL2_EN_BIT])));

endmodule

// File: rtl/outbound_xlate_match.sv
module outbound_xlate_match
  import outbound_xlate_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                reqValid,
  input  logic [ADDR_W-1:0]                   reqAddr,
  input  logic [NUM_REGIONS-1:0]              regEn,
  input  logic [NUM_REGIONS-1:0]              regExt,
  input  logic [NUM_REGIONS-1:0][TYPE_W-1:0]  regType,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  regBase,
  input  logic [NUM_REGIONS-1:0][DATA_W-1:0]  regLimLo,
  input  logic [NUM_REGIONS-1:0][DATA_W-1:0]  regLimHi,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  regTarget,
  output logic                                outValid,
  output logic                                outHit,
  output logic [ADDR_W-1:0]                   outAddr,
  output logic [TYPE_W-1:0]                   outType
);

  localparam logic [NUM_REGIONS-1:0] OUT_MASK = outboundMask();

  logic [NUM_REGIONS-1:0]  rawHit;
  logic [NUM_REGIONS-1:0]  hitVec;
  logic                    anyHit;
  logic [REGION_IDX_W-1:0] winIdx;
  logic [ADDR_W-1:0]       xlatAddr;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gCmp
    logic [ADDR_W-1:0] effLimit;
    assign effLimit  = {regExt[g] ? regLimHi[g] : regBase[g][ADDR_W-1:DATA_W], regLimLo[g]};
    assign rawHit[g] = regEn[g] && (reqAddr >= regBase[g]) && (reqAddr <= effLimit);
  end

  assign hitVec = rawHit & OUT_MASK;

  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        winIdx = REGION_IDX_W'(i);
      end
    end
  end

  assign xlatAddr = regTarget[winIdx] + (reqAddr - regBase[winIdx]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outHit   <= 1'b0;
      outAddr  <= '0;
      outType  <= '0;
    end else begin
      outValid <= reqValid;
      if (reqValid) begin
        outHit  <= anyHit;
        outAddr <= anyHit ? xlatAddr : reqAddr;
        outType <= anyHit ? regType[winIdx] : '0;
      end
    end
  end

  // R11: result valid one cycle after a request, low otherwise
  p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

  // R5: misses pass the address through untouched as memory type
  p_miss_passthru_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !anyHit) |=>
      (!outHit && outAddr == $past(reqAddr) && outType == '0));

  // R4: a hit is always reported as such
  p_hit_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && anyHit) |=> outHit);

endmodule

// File: rtl/outbound_xlate.sv
module outbound_xlate
  import outbound_xlate_pkg::*;
#(
  parameter int REG_AW = 22,
  parameter logic [REG_AW-1:0] REGION_BASE = 22'h300000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              reqValid,
  input  logic [63:0]       reqAddr,
  output logic              outValid,
  output logic              outHit,
  output logic [63:0]       outAddr,
  output logic [4:0]        outType
);

  regStrobe_t                         stb;
  logic [NUM_REGIONS-1:0]             regEn;
  logic [NUM_REGIONS-1:0]             regExt;
  logic [NUM_REGIONS-1:0][TYPE_W-1:0] regType;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] regBase;
  logic [NUM_REGIONS-1:0][DATA_W-1:0] regLimLo;
  logic [NUM_REGIONS-1:0][DATA_W-1:0] regLimHi;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] regTarget;

  outbound_xlate_ctrl #(.REG_AW(REG_AW), .REGION_BASE(REGION_BASE)) i_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .stb     (stb)
  );

  outbound_xlate_regs i_regs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .regEn     (regEn),
    .regExt    (regExt),
    .regType   (regType),
    .regBase   (regBase),
    .regLimLo  (regLimLo),
    .regLimHi  (regLimHi),
    .regTarget (regTarget)
  );

  outbound_xlate_match i_match (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .regEn     (regEn),
    .regExt    (regExt),
    .regType   (regType),
    .regBase   (regBase),
    .regLimLo  (regLimLo),
    .regLimHi  (regLimHi),
    .regTarget (regTarget),
    .outValid  (outValid),
    .outHit    (outHit),
    .outAddr   (outAddr),
    .outType   (outType)
  );

endmodule

// File: tb/test_outbound_xlate.sv
module test_outbound_xlate;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [21:0] regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        reqValid;
  logic [63:0] reqAddr;
  logic        outValid;
  logic        outHit;
  logic [63:0] outAddr;
  logic [4:0]  outType;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  outbound_xlate i_outbound_xlate (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .outValid(outValid), .outHit(outHit),
    .outAddr(outAddr), .outType(outType)
  );

  localparam logic [7:0] O_C1 = 8'h00, O_C2 = 8'h04, O_BL = 8'h08, O_BH = 8'h0C,
                         O_LL = 8'h10, O_TL = 8'h14, O_TH = 8'h18, O_LH = 8'h20;

  function automatic logic [21:0] ra(input int idx, input logic [7:0] ofs);
    return 22'h300000 + 22'(idx * 256) + 22'(ofs);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [21:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(req, 64'(regRdData), 64'(exp));
  endtask

  task automatic lookup(input string req, input logic [63:0] a, input logic expHit,
                        input logic [63:0] expAddr, input logic [4:0] expType);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " valid"}, 64'(outValid), 64'd1);
    check({req, " hit"},   64'(outHit),   64'(expHit));
    check({req, " addr"},  outAddr,       expAddr);
    check({req, " type"},  64'(outType),  64'(expType));
  endtask

  task automatic prog(input int idx, input logic [4:0] typ, input logic ext,
                      input logic [63:0] base, input logic [63:0] lim,
                      input logic [63:0] tgt, input logic en);
    wr(ra(idx, O_C2), 32'h0);
    wr(ra(idx, O_BL), base[31:0]);
    wr(ra(idx, O_BH), base[63:32]);
    wr(ra(idx, O_LL), lim[31:0]);
    wr(ra(idx, O_LH), lim[63:32]);
    wr(ra(idx, O_TL), tgt[31:0]);
    wr(ra(idx, O_TH), tgt[63:32]);
    wr(ra(idx, O_C1), {18'b0, ext, 8'b0, typ});
    wr(ra(idx, O_C2), {en, 31'b0});
  endtask

  task automatic testReset();
    check("R1 outValid", 64'(outValid), 64'd0);
    rdCheck("R1 ctrl2 w0", ra(0, O_C2), 32'h0);
    rdCheck("R1 baseLo w5", ra(5, O_BL), 32'h0);
    rdCheck("R1 ctrl1 w7", ra(7, O_C1), 32'h0);
  endtask

  task automatic testRegs();
    wr(ra(3, O_C1), 32'hFFFFFFFF);
    rdCheck("R2 ctrl1 mask", ra(3, O_C1), 32'h000027FF);
    wr(ra(3, O_C2), 32'hFFFFFFFF);
    rdCheck("R2 ctrl2 mask", ra(3, O_C2), 32'h80000000);
    wr(ra(3, O_TH), 32'hA5A55A5A);
    rdCheck("R2 tgtHi", ra(3, O_TH), 32'hA5A55A5A);
    wr(ra(3, O_LH), 32'h12345678);
    rdCheck("R2 limHi", ra(3, O_LH), 32'h12345678);
    rdCheck("R2 tgtLo untouched", ra(3, O_TL), 32'h0);
    wr(ra(3, O_C2), 32'h0);
  endtask

  task automatic testUnused();
    wr(ra(0, 8'h1C), 32'hDEADBEEF);
    rdCheck("R3 gap 0x1C", ra(0, 8'h1C), 32'h0);
    wr(ra(2, 8'h24), 32'hDEADBEEF);
    rdCheck("R3 gap 0x24", ra(2, 8'h24), 32'h0);
    wr(22'h300800, 32'hFFFFFFFF);
    rdCheck("R3 past window", 22'h300800, 32'h0);
    wr(22'h000000, 32'hFFFFFFFF);
    rdCheck("R3 below window", 22'h000000, 32'h0);
    rdCheck("R3 ctrl1 w0 unchanged", ra(0, O_C1), 32'h0);
    rdCheck("R3 ctrl2 w0 unchanged", ra(0, O_C2), 32'h0);
    rdCheck("R3 limLo w2 unchanged", ra(2, O_LL), 32'h0);
  endtask

  task automatic testBasic();
    prog(0, 5'd0, 1'b0, 64'h18000000, 64'h1FEFFFFF, 64'h1_0000_0000, 1'b1);
    lookup("R4 inside", 64'h18001234, 1'b1, 64'h1_0000_1234, 5'd0);
    lookup("R4 limit inclusive", 64'h1FEFFFFF, 1'b1, 64'h1_07EF_FFFF, 5'd0);
    lookup("R5 above limit", 64'h1FF00000, 1'b0, 64'h1FF00000, 5'd0);
    lookup("R5 below base", 64'h17FFFFFF, 1'b0, 64'h17FFFFFF, 5'd0);
    @(negedge clk);
    check("R11 idle outValid", 64'(outValid), 64'd0);
  endtask

  task automatic testEnable();
    wr(ra(0, O_C2), 32'h0);
    lookup("R6 disabled", 64'h18001234, 1'b0, 64'h18001234, 5'd0);
    wr(ra(0, O_C2), 32'h80000000);
    lookup("R11 write then use", 64'h18001234, 1'b1, 64'h1_0000_1234, 5'd0);
  endtask

  task automatic testOdd();
    prog(1, 5'd0, 1'b0, 64'h40000000, 64'h4000FFFF, 64'h90000000, 1'b1);
    rdCheck("R7 odd enable stored", ra(1, O_C2), 32'h80000000);
    lookup("R7 odd ignored", 64'h40000100, 1'b0, 64'h40000100, 5'd0);
  endtask

  task automatic testPriority();
    prog(2, 5'd2, 1'b0, 64'h1FF80000, 64'h1FF8FFFF, 64'h1FF80000, 1'b1);
    prog(4, 5'd0, 1'b0, 64'h1FF00000, 64'h1FFFFFFF, 64'h50000000, 1'b1);
    lookup("R9 lower wins", 64'h1FF80010, 1'b1, 64'h1FF80010, 5'd2);
    lookup("R9 only upper", 64'h1FF90000, 1'b1, 64'h50090000, 5'd0);
    wr(ra(4, O_C2), 32'h0);
  endtask

  task automatic testConfig();
    prog(6, 5'd4, 1'b0, 64'h1FF00000, 64'h1FF7FFFF, 64'h032A0000, 1'b1);
    lookup("R10 cfg0 routing", 64'h1FF00ABC, 1'b1, 64'h032A0ABC, 5'd4);
    wr(ra(6, O_C1), 32'h5);
    lookup("R10 cfg1 routing", 64'h1FF00004, 1'b1, 64'h032A0004, 5'd5);
    wr(ra(6, O_C2), 32'h0);
  endtask

  task automatic testExtended();
    prog(6, 5'd0, 1'b0, 64'h1_0000_0000, 64'h2_FFFF_FFFF, 64'h0, 1'b1);
    lookup("R8 ext off inside", 64'h1_8000_0000, 1'b1, 64'h8000_0000, 5'd0);
    lookup("R8 ext off cut", 64'h2_0000_0010, 1'b0, 64'h2_0000_0010, 5'd0);
    wr(ra(6, O_C1), 32'h00002000);
    lookup("R8 ext on reach", 64'h2_0000_0010, 1'b1, 64'h1_0000_0010, 5'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    reqValid = 1'b0; reqAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testUnused();
    testBasic();
    testEnable();
    testOdd();
    testPriority();
    testConfig();
    testExtended();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule